// File: doc/BRIEF.md
# Bus-Cycle Breakpoint Channel with Match Counter

This block is a single breakpoint channel of a debug break controller. It watches the bus cycles of two masters, the processor and a DMA engine. Each cycle is compared against a programmed address, an address mask, an access-kind filter (instruction fetch or data) and a direction filter (read or write). A processor match and a DMA match each set their own sticky status flag. Software clears a flag by writing to the control register.

The channel drives a single break-interrupt request. By default every match raises the request for one cycle. When count gating is on, the request is held back until a programmed number of matches has occurred, and then the count starts over. For a processor instruction-fetch match the break can be placed either before the instruction executes (raised at once) or after it (raised when the instruction-retire strobe arrives).

Software reaches four 32-bit registers through a one-cycle write port and a combinational read port. Index 0 is control/status, index 1 is the compare address, index 2 is the address mask, and index 3 is the match-count limit.

Top module: `brk_chan`

## Requirements
- R1: After reset all four registers read 0, the internal match count is 0 and `brk_irq` is 0.
- R2: A master's cycle matches only if that master is enabled (control bit 0 for the processor, bit 1 for DMA), its valid strobe is high, and its address equals the compare address in every bit where the mask register holds 0. Mask bits set to 1 are don't-care.
- R3: Control bits [5:4] filter the access kind: 1 = fetch only, 2 = data only, 0 or 3 = any. Control bits [7:6] filter the direction: 1 = read only, 2 = write only, 0 or 3 = any. DMA cycles are always data cycles.
- R4: A processor match sets control bit 8. A DMA match sets control bit 9. Both are set if both masters match in the same cycle. Each flag stays set until software clears it, and is visible on the cycle after the match.
- R5: A write to control with bit 8 (or bit 9) at 0 clears that flag. A 1 in that position leaves the flag unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R6: With count gating off (control bit 2 = 0), each matching cycle that is not deferred drives `brk_irq` high for exactly the following cycle.
- R7: With count gating on, a cycle in which either master or both match counts as one event. `brk_irq` is raised after the event that brings the count to the limit in register 3 (bits [7:0]), and the count then restarts from 0. A limit of 0 or 1 fires on every event.
- R8: With control bit 3 = 1, a firing event that contains a processor instruction-fetch match is deferred. `brk_irq` is raised on the cycle after the first `insn_retire` pulse that comes later than the match cycle. With bit 3 = 0, or for data matches, the break is not deferred.
- R9: Control bits above 9 and limit bits above 7 always read 0, and writes to them have no effect.
- R10: Any write to the control register or to the limit register restarts the match count from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 control, 1 address, 2 mask, 3 limit) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cpu_valid | input | 1 | Processor bus cycle valid |
| cpu_addr | input | 32 | Processor cycle address |
| cpu_fetch | input | 1 | Processor cycle is an instruction fetch |
| cpu_wr | input | 1 | Processor cycle is a write |
| dma_valid | input | 1 | DMA bus cycle valid |
| dma_addr | input | 32 | DMA cycle address |
| dma_wr | input | 1 | DMA cycle is a write |
| insn_retire | input | 1 | Instruction-retire strobe |
| brk_irq | output | 1 | Break-interrupt request |

## Verification
Address patterns inside and just outside the masked window separate mask handling from exact compare. Fetch, data, read and write cycles under each filter setting show that every filter rejects exactly the cycles it should. Processor-only, DMA-only and simultaneous matches distinguish the two sticky flags, and also confirm that a simultaneous match counts once. Runs with count gating, limit rewrites, the deferred fetch mode with late retire pulses, and clearing writes that coincide with matches cover the timing corners.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        KIND_ANY   = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_DATA  = 2'd2,
        KIND_ALL   = 2'd3
    } kind_sel_t;

    typedef enum logic [1:0] {
        DIR_ANY   = 2'd0,
        DIR_READ  = 2'd1,
        DIR_WRITE = 2'd2,
        DIR_ALL   = 2'd3
    } dir_sel_t;

    // Control/status register layout, bit 9 down to bit 0
    typedef struct packed {
        logic      dma_flag;
        logic      cpu_flag;
        dir_sel_t  dir;
        kind_sel_t kind;
        logic      after_exec;
        logic      cnt_en;
        logic      dma_en;
        logic      cpu_en;
    } ctrl_t;

    localparam int CTRL_BITS = 10;
    localparam int CPU_FLAG_BIT = 8;
    localparam int DMA_FLAG_BIT = 9;

    localparam logic [1:0] IDX_CTRL  = 2'd0;
    localparam logic [1:0] IDX_ADDR  = 2'd1;
    localparam logic [1:0] IDX_MASK  = 2'd2;
    localparam logic [1:0] IDX_LIMIT = 2'd3;

endpackage

// File: rtl/brk_cmp.sv
module brk_cmp
    import brk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          en,
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic          is_fetch,
    input  logic          is_wr,
    input  logic [AW-1:0] cmp_addr,
    input  logic [AW-1:0] cmp_mask,
    input  kind_sel_t     kind,
    input  dir_sel_t      dir,
    output logic          hit
);
    logic addr_ok;
    logic kind_ok;
    logic dir_ok;

    always_comb begin
        addr_ok = ((addr ^ cmp_addr) & ~cmp_mask) == '0;
        unique case (kind)
            KIND_FETCH: kind_ok = is_fetch;
            KIND_DATA:  kind_ok = ~is_fetch;
            default:    kind_ok = 1'b1;
        endcase
        unique case (dir)
            DIR_READ:  dir_ok = ~is_wr;
            DIR_WRITE: dir_ok = is_wr;
            default:   dir_ok = 1'b1;
        endcase
        hit = en & valid & addr_ok & kind_ok & dir_ok;
    end
endmodule

// File: rtl/brk_cnt.sv
module brk_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_en,
    input  logic          ev,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          fire,
    output logic [CW-1:0] cnt
);
    localparam logic [CW:0] ONE = (CW+1)'(1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   nxt;
    logic          reached;

    always_comb begin
        nxt     = {1'b0, cnt_q} + ONE;
        reached = (limit <= CW'(1)) || (nxt >= {1'b0, limit});
        fire    = ev & (~gate_en | reached);
        cnt_d   = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (gate_en && ev) begin
            cnt_d = reached ? '0 : nxt[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          cpu_valid,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_fetch,
    input  logic          cpu_wr,
    input  logic          dma_valid,
    input  logic [AW-1:0] dma_addr,
    input  logic          dma_wr,
    input  logic          insn_retire,
    output logic          brk_irq
);
    localparam int NM = 2;  // 0: processor, 1: DMA

    typedef struct packed {
        ctrl_t         ctrl;
        logic [AW-1:0] cmp;
        logic [AW-1:0] mask;
        logic [CW-1:0] limit;
        logic          pend;
        logic          irq;
    } state_t;

    state_t st_d, st_q;

    logic          m_en    [NM];
    logic          m_valid [NM];
    logic [AW-1:0] m_addr  [NM];
    logic          m_fetch [NM];
    logic          m_wr    [NM];
    logic [NM-1:0] hit;

    assign m_en[0]    = st_q.ctrl.cpu_en;
    assign m_valid[0] = cpu_valid;
    assign m_addr[0]  = cpu_addr;
    assign m_fetch[0] = cpu_fetch;
    assign m_wr[0]    = cpu_wr;
    assign m_en[1]    = st_q.ctrl.dma_en;
    assign m_valid[1] = dma_valid;
    assign m_addr[1]  = dma_addr;
    assign m_fetch[1] = 1'b0;
    assign m_wr[1]    = dma_wr;

    for (genvar g = 0; g < NM; g++) begin : g_cmp
        brk_cmp #(.AW(AW)) cmp_i (
            .en       (m_en[g]),
            .valid    (m_valid[g]),
            .addr     (m_addr[g]),
            .is_fetch (m_fetch[g]),
            .is_wr    (m_wr[g]),
            .cmp_addr (st_q.cmp),
            .cmp_mask (st_q.mask),
            .kind     (st_q.ctrl.kind),
            .dir      (st_q.ctrl.dir),
            .hit      (hit[g])
        );
    end

    logic          wr_ctrl, wr_limit, fire, defer;
    logic [CW-1:0] cnt_w;

    assign wr_ctrl  = reg_wr && (reg_addr == IDX_CTRL);
    assign wr_limit = reg_wr && (reg_addr == IDX_LIMIT);

    brk_cnt #(.CW(CW)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (st_q.ctrl.cnt_en),
        .ev      (|hit),
        .clr     (wr_ctrl | wr_limit),
        .limit   (st_q.limit),
        .fire    (fire),
        .cnt     (cnt_w)
    );

    always_comb begin
        st_d  = st_q;
        defer = st_q.ctrl.after_exec & hit[0] & cpu_fetch;

        st_d.irq  = (fire & ~defer) | (st_q.pend & insn_retire);
        st_d.pend = (st_q.pend & ~insn_retire) | (fire & defer);

        if (wr_ctrl) begin
            st_d.ctrl.cpu_en     = reg_wdata[0];
            st_d.ctrl.dma_en     = reg_wdata[1];
            st_d.ctrl.cnt_en     = reg_wdata[2];
            st_d.ctrl.after_exec = reg_wdata[3];
            st_d.ctrl.kind       = kind_sel_t'(reg_wdata[5:4]);
            st_d.ctrl.dir        = dir_sel_t'(reg_wdata[7:6]);
        end
        st_d.ctrl.cpu_flag = (st_q.ctrl.cpu_flag & ~(wr_ctrl & ~reg_wdata[CPU_FLAG_BIT])) | hit[0];
        st_d.ctrl.dma_flag = (st_q.ctrl.dma_flag & ~(wr_ctrl & ~reg_wdata[DMA_FLAG_BIT])) | hit[1];

        if (reg_wr && reg_addr == IDX_ADDR) st_d.cmp   = reg_wdata[AW-1:0];
        if (reg_wr && reg_addr == IDX_MASK) st_d.mask  = reg_wdata[AW-1:0];
        if (wr_limit)                       st_d.limit = reg_wdata[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            IDX_CTRL:  reg_rdata = DW'(st_q.ctrl);
            IDX_ADDR:  reg_rdata = DW'(st_q.cmp);
            IDX_MASK:  reg_rdata = DW'(st_q.mask);
            default:   reg_rdata = DW'(st_q.limit);
        endcase
    end

    assign brk_irq = st_q.irq;

    // Plain views for the bound checker
    logic flag_cpu, flag_dma, cnt_on, after_on, pend_on;
    logic [CW-1:0] limit_v;
    assign flag_cpu = st_q.ctrl.cpu_flag;
    assign flag_dma = st_q.ctrl.dma_flag;
    assign cnt_on   = st_q.ctrl.cnt_en;
    assign after_on = st_q.ctrl.after_exec;
    assign pend_on  = st_q.pend;
    assign limit_v  = st_q.limit;
endmodule

// File: rtl/brk_chan_chk.sv
module brk_chan_chk #(
    parameter int CW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          insn_retire,
    input logic          brk_irq,
    input logic [1:0]    hit,
    input logic          flag_cpu,
    input logic          flag_dma,
    input logic          cnt_on,
    input logic          after_on,
    input logic          pend_on,
    input logic [CW-1:0] limit_v,
    input logic [CW-1:0] cnt_w
);
    AST_CPU_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n) hit[0] |=> flag_cpu); // R4
    AST_DMA_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n) hit[1] |=> flag_dma); // R4
    AST_CPU_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cpu && !(reg_wr && reg_addr == 2'd0 && !reg_wdata[8])) |=> flag_cpu); // R5
    AST_PLAIN_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hit) && !cnt_on && !after_on) |=> brk_irq); // R6
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_on && limit_v > CW'(1)) |-> (cnt_w < limit_v)); // R7
    AST_RETIRE_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_on && insn_retire) |=> brk_irq); // R8
    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[DW-1:10] == '0)); // R9
endmodule

bind brk_chan brk_chan_chk #(.CW(CW), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .insn_retire (insn_retire),
    .brk_irq     (brk_irq),
    .hit         (hit),
    .flag_cpu    (flag_cpu),
    .flag_dma    (flag_dma),
    .cnt_on      (cnt_on),
    .after_on    (after_on),
    .pend_on     (pend_on),
    .limit_v     (limit_v),
    .cnt_w       (cnt_w)
);

// File: tb/brk_chan_tb_top.sv
module brk_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_fetch = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        dma_valid = 1'b0;
    logic [31:0] dma_addr = '0;
    logic        dma_wr = 1'b0;
    logic        insn_retire = 1'b0;
    logic        brk_irq;

    always #4 clk = ~clk;  // 125 MHz

    brk_chan dut_i (.*);

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";

    // Behavioural reference state
    bit          m_cpu_en, m_dma_en, m_cnt_en, m_after, m_fc, m_fd, m_pend, m_irq;
    int          m_kind, m_dir, m_lim, m_cnt;
    bit [31:0]   m_cmp, m_mask;

    function automatic bit m_match(bit en, bit v, bit [31:0] a, bit f, bit w);
        bit ok;
        ok = en && v && (((a ^ m_cmp) & ~m_mask) == 32'd0);
        if (m_kind == 1 && !f) ok = 0;
        if (m_kind == 2 && f) ok = 0;
        if (m_dir == 1 && w) ok = 0;
        if (m_dir == 2 && !w) ok = 0;
        return ok;
    endfunction

    function automatic bit [31:0] m_read(int idx);
        case (idx)
            0: return {22'd0, m_fd, m_fc, 2'(m_dir), 2'(m_kind), m_after, m_cnt_en, m_dma_en, m_cpu_en};
            1: return m_cmp;
            2: return m_mask;
            default: return 32'(m_lim);
        endcase
    endfunction

    task automatic check(string what, bit [31:0] act, bit [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit ch, dh, ev, fire, defer, wc;
        if (!rst_n) begin
            m_cpu_en = 0; m_dma_en = 0; m_cnt_en = 0; m_after = 0; m_fc = 0; m_fd = 0;
            m_pend = 0; m_irq = 0; m_kind = 0; m_dir = 0; m_lim = 0; m_cnt = 0;
            m_cmp = 0; m_mask = 0;
        end else begin
            ch = m_match(m_cpu_en, cpu_valid, cpu_addr, cpu_fetch, cpu_wr);
            dh = m_match(m_dma_en, dma_valid, dma_addr, 1'b0, dma_wr);
            ev = ch || dh;
            fire = 0;
            if (ev) begin
                if (!m_cnt_en) fire = 1;
                else if (m_lim <= 1 || m_cnt + 1 >= m_lim) begin fire = 1; m_cnt = 0; end
                else m_cnt++;
            end
            defer = m_after && ch && cpu_fetch;
            m_irq = (fire && !defer) || (m_pend && insn_retire);
            m_pend = (m_pend && !insn_retire) || (fire && defer);
            wc = reg_wr && reg_addr == 2'd0;
            m_fc = (m_fc && !(wc && !reg_wdata[8])) || ch;
            m_fd = (m_fd && !(wc && !reg_wdata[9])) || dh;
            if (wc) begin
                m_cpu_en = reg_wdata[0]; m_dma_en = reg_wdata[1]; m_cnt_en = reg_wdata[2];
                m_after = reg_wdata[3]; m_kind = int'(reg_wdata[5:4]); m_dir = int'(reg_wdata[7:6]);
            end
            if (reg_wr && reg_addr == 2'd1) m_cmp = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_mask = reg_wdata;
            if (reg_wr && reg_addr == 2'd3) m_lim = int'(reg_wdata[7:0]);
            if (wc || (reg_wr && reg_addr == 2'd3)) m_cnt = 0;
        end
        #2;
        check("brk_irq", 32'(brk_irq), 32'(m_irq));
        check("reg_rdata", reg_rdata, m_read(int'(reg_addr)));
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(bit [1:0] a, bit [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd(bit [1:0] a);
        reg_addr = a;
        @(negedge clk);
    endtask

    task automatic cpu(bit [31:0] a, bit f, bit w);
        cpu_valid = 1; cpu_addr = a; cpu_fetch = f; cpu_wr = w;
        @(negedge clk);
        cpu_valid = 0; cpu_fetch = 0; cpu_wr = 0;
    endtask

    task automatic dma(bit [31:0] a, bit w);
        dma_valid = 1; dma_addr = a; dma_wr = w;
        @(negedge clk);
        dma_valid = 0; dma_wr = 0;
    endtask

    task automatic both(bit [31:0] a);
        cpu_valid = 1; cpu_addr = a; dma_valid = 1; dma_addr = a;
        @(negedge clk);
        cpu_valid = 0; dma_valid = 0;
    endtask

    task automatic retire();
        insn_retire = 1;
        @(negedge clk);
        insn_retire = 0;
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin @(posedge clk); wd++; end
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(3);
        rst_n = 1;
        rd(0); rd(1); rd(2); rd(3);

        cur_req = "R9";
        wr(0, 32'hFFFF_FFFF); rd(0);
        wr(3, 32'hFFFF_FFFF); rd(3);
        wr(0, 32'h0); wr(3, 32'h0); rd(0);

        cur_req = "R2";
        wr(1, 32'h0000_1000); wr(2, 32'h0000_000F); wr(0, 32'h1);
        rd(0);
        cpu(32'h0000_100A, 0, 0); idle(1);
        cpu(32'h0000_1010, 0, 0); idle(1);
        wr(0, 32'h0); cpu(32'h0000_1000, 0, 0);
        dma(32'h0000_1000, 0); idle(1);
        wr(2, 32'h0); wr(0, 32'h1);
        cpu(32'h0000_1001, 0, 0); cpu(32'h0000_1000, 0, 0); idle(1);

        cur_req = "R3";
        wr(0, 32'h1 | (1 << 4));
        cpu(32'h1000, 0, 0); cpu(32'h1000, 1, 0); idle(1);
        wr(0, 32'h1 | (2 << 4));
        cpu(32'h1000, 1, 0); cpu(32'h1000, 0, 1); idle(1);
        wr(0, 32'h1 | (2 << 6));
        cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 1); idle(1);
        wr(0, 32'h1 | (1 << 6));
        cpu(32'h1000, 0, 1); cpu(32'h1000, 0, 0); idle(1);
        wr(0, 32'h2 | (1 << 4));
        dma(32'h1000, 0); idle(1);
        wr(0, 32'h2 | (2 << 4));
        dma(32'h1000, 1); idle(1);

        cur_req = "R4";
        wr(0, 32'h3);
        cpu(32'h1000, 0, 0); idle(1);
        wr(0, 32'h3);
        dma(32'h1000, 0); idle(1);
        wr(0, 32'h3);
        both(32'h1000); idle(2);

        cur_req = "R5";
        wr(0, 32'h303); rd(0);
        wr(0, 32'h203); rd(0);
        wr(0, 32'h103); rd(0);
        cpu_valid = 1; cpu_addr = 32'h1000;
        wr(0, 32'h3);
        cpu_valid = 0; rd(0);
        wr(0, 32'h3);

        cur_req = "R6";
        cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0); idle(2);
        dma(32'h1000, 0); idle(2);

        cur_req = "R7";
        wr(3, 32'd3); wr(0, 32'h7);
        cpu(32'h1000, 0, 0); idle(1); cpu(32'h1000, 0, 0); idle(1);
        cpu(32'h1000, 0, 0); idle(1);
        both(32'h1000); both(32'h1000); both(32'h1000); idle(2);
        wr(3, 32'd0);
        cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0); idle(1);
        wr(3, 32'd1);
        dma(32'h1000, 0); idle(1);

        cur_req = "R10";
        wr(3, 32'd3);
        cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0);
        wr(3, 32'd3);
        cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0); idle(1);
        cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0);
        wr(0, 32'h7);
        cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0); cpu(32'h1000, 0, 0); idle(2);

        cur_req = "R8";
        wr(0, 32'h9);
        cpu(32'h1000, 1, 0); idle(3);
        retire(); idle(2);
        retire(); idle(1);
        cpu_valid = 1; cpu_addr = 32'h1000; cpu_fetch = 1; insn_retire = 1;
        @(negedge clk);
        cpu_valid = 0; cpu_fetch = 0; insn_retire = 0;
        idle(2); retire(); idle(1);
        cpu(32'h1000, 0, 0); idle(1);
        wr(0, 32'h1);
        cpu(32'h1000, 1, 0); idle(2);
        wr(0, 32'hD); wr(3, 32'd2);
        cpu(32'h1000, 1, 0); idle(1); cpu(32'h1000, 1, 0); idle(2);
        retire(); idle(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule